// File: doc/BRIEF.md
# LRU Way Replacement Tracker

This block keeps the recency order of the ways in one cache set, or of all lines in a fully-associative cache. It then names, at every moment, the way that the next line fill should evict. The surrounding cache owns tag and data storage and hit detection. It reports each event to the tracker with four command signals and a way index. Each set of a set-associative cache has its own instance, so no state is shared between sets.

Internally the tracker holds an ordered list of way indices. Slot 0 is the least recently used way and slot N-1 is the most recently used. The victim output is slot 0 taken straight from the register, with no logic after it.

A read hit or a write hit promotes the accessed way to the most-recent slot. An invalidate demotes the accessed way to the least-recent slot, so it becomes the next victim. A replace promotes the current victim, because the freshly filled line counts as the latest use. Every other command is a no-op.

Top module: `lru_way_tracker`

## Requirements
- R1: A synchronous active-low reset sets the order to way 0 as least recent up to way N-1 as most recent. Right after reset `victim_way` is 0, and N replace commands in a row then report victims 0, 1, ..., N-1.
- R2: When `tag_access` and `replace` are both 0, the recency order does not change, whatever `write_sel`, `invalidate` and `hit_way` are.
- R3: A read hit (`tag_access`=1, `write_sel`=0, `invalidate`=0, `replace`=0) moves `hit_way` to the most-recent slot. Ways that were more recent than it move down one slot, and ways that were less recent keep their slots.
- R4: A write hit (`tag_access`=1, `write_sel`=1, `invalidate`=0, `replace`=0) updates the order exactly as a read hit does.
- R5: An invalidate (`tag_access`=1, `invalidate`=1, `replace`=0, `write_sel` either value) moves `hit_way` to the least-recent slot, keeping the relative order of the other ways. From the next cycle `victim_way` equals that way.
- R6: A replace (`replace`=1, `tag_access`=0, `invalidate`=0) moves the current victim to the most-recent slot. The way that was second least recent becomes the new victim.
- R7: Combinations outside the command table are no-ops and leave the order unchanged. These are `tag_access`=1 with `replace`=1, and `replace`=1 with `invalidate`=1.
- R8: The order always holds each way index exactly once. `victim_way` reflects a command in the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tag_access | input | 1 | Marks a tag access (hit or invalidate) this cycle |
| write_sel | input | 1 | Hit kind: 0 read, 1 write |
| invalidate | input | 1 | With `tag_access`, invalidates `hit_way` |
| replace | input | 1 | Line fill that evicts the current victim |
| hit_way | input | WAY_W | Way addressed by a hit or invalidate |
| victim_way | output | WAY_W | Way the next replace evicts |

## Verification
Random mixes of read hits, write hits, invalidates and replaces on random ways are compared against a queue model. Replaces rotate the list through slot 0, so wrong ordering deep in the list surfaces at the victim output. This separates correct promotion from a list that only tracks the top entry. Directed runs follow. A replace sweep after reset exposes the initial order. Invalidates with both `write_sel` values separate demotion from promotion. Idle cycles and illegal combinations with `invalidate` and `hit_way` toggling show that state is held. Hits on the victim, on the most recent way and on a middle way exercise each shift boundary.

// File: rtl/lru_track_pkg.sv
package lru_track_pkg;
  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_HIT_RD  = 3'd1,
    CMD_HIT_WR  = 3'd2,
    CMD_INVAL   = 3'd3,
    CMD_REPLACE = 3'd4
  } lru_cmd_e;

  function automatic lru_cmd_e decode_cmd(input logic acc, input logic wr,
                                          input logic inv, input logic rpl);
    lru_cmd_e c;
    c = CMD_NOP;
    if (acc && !rpl) begin
      if (inv)     c = CMD_INVAL;
      else if (wr) c = CMD_HIT_WR;
      else         c = CMD_HIT_RD;
    end else if (!acc && rpl && !inv) begin
      c = CMD_REPLACE;
    end
    return c;
  endfunction
endpackage

// File: rtl/lru_cmd_decode.sv
module lru_cmd_decode
  import lru_track_pkg::*;
(
  input  logic     tag_access,
  input  logic     write_sel,
  input  logic     invalidate,
  input  logic     replace,
  output lru_cmd_e cmd
);
  always_comb cmd = decode_cmd(tag_access, write_sel, invalidate, replace);
endmodule

// File: rtl/lru_order_next.sv
module lru_order_next
  import lru_track_pkg::*;
#(
  parameter int NWAYS = 4,
  parameter int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
  input  lru_cmd_e                 cmd,
  input  logic [WAY_W-1:0]         hit_way,
  input  logic [NWAYS*WAY_W-1:0]   order_q,
  output logic [NWAYS*WAY_W-1:0]   order_d,
  output logic                     way_found
);
  localparam int FLAT = NWAYS * WAY_W;

  function automatic int find_slot(input logic [FLAT-1:0] ord, input logic [WAY_W-1:0] w);
    int p;
    p = -1;
    for (int i = 0; i < NWAYS; i++)
      if (p < 0 && ord[i*WAY_W +: WAY_W] == w) p = i;
    return p;
  endfunction

  // Move w to the most-recent slot; those above it slide down one slot.
  function automatic logic [FLAT-1:0] promote(input logic [FLAT-1:0] ord, input logic [WAY_W-1:0] w);
    logic [FLAT-1:0] r;
    int p;
    r = ord;
    p = find_slot(ord, w);
    if (p >= 0) begin
      for (int i = 0; i < NWAYS - 1; i++)
        if (i >= p) r[i*WAY_W +: WAY_W] = ord[(i+1)*WAY_W +: WAY_W];
      r[(NWAYS-1)*WAY_W +: WAY_W] = w;
    end
    return r;
  endfunction

  // Move w to the least-recent slot; those below it slide up one slot.
  function automatic logic [FLAT-1:0] demote(input logic [FLAT-1:0] ord, input logic [WAY_W-1:0] w);
    logic [FLAT-1:0] r;
    int p;
    r = ord;
    p = find_slot(ord, w);
    if (p >= 0) begin
      for (int i = 1; i < NWAYS; i++)
        if (i <= p) r[i*WAY_W +: WAY_W] = ord[(i-1)*WAY_W +: WAY_W];
      r[WAY_W-1:0] = w;
    end
    return r;
  endfunction

  always_comb begin
    way_found = (find_slot(order_q, hit_way) >= 0);
    unique case (cmd)
      CMD_HIT_RD, CMD_HIT_WR: order_d = promote(order_q, hit_way);
      CMD_INVAL:              order_d = demote(order_q, hit_way);
      CMD_REPLACE:            order_d = promote(order_q, order_q[WAY_W-1:0]);
      default:                order_d = order_q;
    endcase
  end
endmodule

// File: rtl/lru_way_tracker.sv
module lru_way_tracker
  import lru_track_pkg::*;
#(
  parameter int NWAYS = 4,
  parameter int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tag_access,
  input  logic             write_sel,
  input  logic             invalidate,
  input  logic             replace,
  input  logic [WAY_W-1:0] hit_way,
  output logic [WAY_W-1:0] victim_way
);
  localparam int FLAT = NWAYS * WAY_W;

  function automatic logic [FLAT-1:0] reset_order();
    logic [FLAT-1:0] r;
    r = '0;
    for (int i = 0; i < NWAYS; i++) r[i*WAY_W +: WAY_W] = WAY_W'(i);
    return r;
  endfunction

  function automatic logic is_permutation(input logic [FLAT-1:0] ord);
    logic ok;
    int cnt;
    ok = 1'b1;
    for (int w = 0; w < NWAYS; w++) begin
      cnt = 0;
      for (int i = 0; i < NWAYS; i++)
        if (ord[i*WAY_W +: WAY_W] == WAY_W'(w)) cnt++;
      if (cnt != 1) ok = 1'b0;
    end
    return ok;
  endfunction

  lru_cmd_e        cmd;
  logic [FLAT-1:0] order_q, order_d;
  logic            way_found;
  logic [WAY_W-1:0] mru_way;

  lru_cmd_decode u_decode (
    .tag_access (tag_access),
    .write_sel  (write_sel),
    .invalidate (invalidate),
    .replace    (replace),
    .cmd        (cmd)
  );

  lru_order_next #(.NWAYS(NWAYS), .WAY_W(WAY_W)) u_next (
    .cmd       (cmd),
    .hit_way   (hit_way),
    .order_q   (order_q),
    .order_d   (order_d),
    .way_found (way_found)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) order_q <= reset_order();
    else        order_q <= order_d;
  end

  assign victim_way = order_q[WAY_W-1:0];
  assign mru_way    = order_q[(NWAYS-1)*WAY_W +: WAY_W];

  wire ev_hit   = (cmd == CMD_HIT_RD) || (cmd == CMD_HIT_WR);
  wire ev_inval = (cmd == CMD_INVAL);
  wire ev_fill  = (cmd == CMD_REPLACE);
  wire ev_idle  = (cmd == CMD_NOP);

  // R1
  reset_order_chk: assert property (@(posedge clk)
    !rst_n |=> (order_q == reset_order()));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tag_access && !replace) |=> $stable(order_q));

  // R7
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (replace && (tag_access || invalidate)) |=> $stable(order_q));

  // R3
  hit_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && way_found) |=> (mru_way == $past(hit_way)));

  // R5
  inval_demote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_inval && way_found) |=> (victim_way == $past(hit_way)));

  // R6
  fill_promote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> (mru_way == $past(victim_way)));

  // R8
  order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle || ev_hit || ev_inval || ev_fill |=> is_permutation(order_q));
endmodule

// File: tb/lru_way_tracker_bench.sv
module lru_way_tracker_bench;
  localparam int NWAYS = 4;
  localparam int WAY_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tag_access = 0, write_sel = 0, invalidate = 0, replace = 0;
  logic [WAY_W-1:0] hit_way = '0;
  logic [WAY_W-1:0] victim_way;

  int checks = 0;
  int errors = 0;
  int model[$];

  always #5 clk = ~clk;

  lru_way_tracker #(.NWAYS(NWAYS), .WAY_W(WAY_W)) u_lru_way_tracker (
    .clk(clk), .rst_n(rst_n), .tag_access(tag_access), .write_sel(write_sel),
    .invalidate(invalidate), .replace(replace), .hit_way(hit_way),
    .victim_way(victim_way)
  );

  function automatic int slot_of(int w);
    foreach (model[i]) if (model[i] == w) return i;
    return -1;
  endfunction

  function automatic string apply_model(bit acc, bit wr, bit inv, bit rpl, int w);
    int s, v;
    if (acc && !rpl && !inv) begin
      s = slot_of(w); model.delete(s); model.push_back(w);
      return wr ? "R4" : "R3";
    end
    if (acc && !rpl && inv) begin
      s = slot_of(w); model.delete(s); model.push_front(w);
      return "R5";
    end
    if (!acc && rpl && !inv) begin
      v = model.pop_front(); model.push_back(v);
      return "R6";
    end
    if (!acc && !rpl) return "R2";
    return "R7";
  endfunction

  task automatic check_victim(string tag);
    checks++;
    if (int'(victim_way) != model[0]) begin
      errors++;
      $display("FAIL %s: victim_way=%0d expected %0d", tag, victim_way, model[0]);
    end
  endtask

  task automatic step(bit acc, bit wr, bit inv, bit rpl, int w);
    string tag;
    @(negedge clk);
    tag_access = acc; write_sel = wr; invalidate = inv; replace = rpl;
    hit_way = WAY_W'(w);
    @(posedge clk);
    tag = apply_model(acc, wr, inv, rpl, w);
    #1;
    check_victim(tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    tag_access = 0; replace = 0; invalidate = 0; write_sel = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst_n = 1;
    model = {};
    for (int i = 0; i < NWAYS; i++) model.push_back(i);
    check_victim("R1");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1: replace sweep reveals initial order 0,1,2,3 then wraps
    for (int i = 0; i <= NWAYS; i++) step(0, 0, 0, 1, 0);
    // R3: hit current victim, middle way, MRU way
    step(1, 0, 0, 0, model[0]);
    step(1, 0, 0, 0, model[2]);
    step(1, 0, 0, 0, model[NWAYS-1]);
    // R4: write hit
    step(1, 1, 0, 0, model[1]);
    // R5: invalidate with both write_sel values, including MRU and victim
    step(1, 0, 1, 0, model[NWAYS-1]);
    step(1, 1, 1, 0, model[2]);
    step(1, 0, 1, 0, model[0]);
    // R2: idle cycles with other inputs toggling
    step(0, 1, 1, 0, 3);
    step(0, 0, 1, 0, 1);
    // R7: illegal combinations
    step(1, 0, 0, 1, model[0]);
    step(1, 1, 1, 1, model[1]);
    step(0, 0, 1, 1, model[2]);
    // R6: replace sweep exposes the whole order
    for (int i = 0; i < NWAYS; i++) step(0, 0, 0, 1, 0);
    // Random mix (R2..R8)
    for (int n = 0; n < 600; n++) begin
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0, 1, 2: step(1, 1'($urandom_range(0, 1)), 0, 0, $urandom_range(0, NWAYS-1));
        3, 4:    step(1, 1'($urandom_range(0, 1)), 1, 0, $urandom_range(0, NWAYS-1));
        5, 6:    step(0, 0, 0, 1, $urandom_range(0, NWAYS-1));
        7:       step(0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0,
                      $urandom_range(0, NWAYS-1));
        default: step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1, 1,
                      $urandom_range(0, NWAYS-1));
      endcase
    end
    // R1: reset again in mid-run
    do_reset();
    step(0, 0, 0, 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule